// File: doc/BRIEF.md
# Macro-Instruction Retirement Buffer

This block keeps architectural instructions in program order while their micro-operations finish out of order. Each instruction takes a single slot in a circular window, whether it was cracked into one micro-op or into up to four. On allocation the front end gives the instruction address, the number of micro-ops and one physical destination tag per micro-op. In the same cycle the block shows the slot index the instruction will take. Every micro-op carries that short index instead of the full address.

Execution units report completion by sending the slot index, the micro-op position and an optional exception code. The oldest instruction leaves the window only after all of its micro-ops have reported. If none of them raised an exception, the instruction retires and its address and destination tags are presented. If any did, the block reports a fault against the parent instruction address, empties the whole window and requests a pipeline flush. Completed siblings of the faulting micro-op are thrown away along with everything younger. Rename tables, the register file, the execution units and store handling are outside this block.

Top module: `mop_retire_buffer`

## Requirements
- R1: After synchronous reset the window is empty: `alloc_ready` is 1, `alloc_idx` is 0, and `ret_valid` and `flush_valid` are 0.
- R2: Each accepted allocation (`alloc_valid` and `alloc_ready` both high at a clock edge) takes exactly one slot, with index `alloc_idx`. After that edge, `alloc_idx` has moved on by one, modulo DEPTH.
- R3: When DEPTH instructions are held, `alloc_ready` is 0 and `alloc_valid` has no effect: `alloc_idx` does not change and no instruction is added.
- R4: Instructions retire strictly oldest first, at most one per cycle. The head retires only once all of its micro-ops have been written back, where the micro-op count is `alloc_nuop_m1`+1. `ret_valid` is high in the cycle after the clock edge at which the head was found complete and fault-free.
- R5: Writebacks may arrive in any order. A writeback is ignored, including any exception it carries, if it targets a slot that holds no instruction, a micro-op position at or beyond the instruction's count, or a position that has already been written back.
- R6: While `ret_valid` is high, `ret_pc`, `ret_nuop_m1` and `ret_ptags` show what was allocated for the retiring instruction. Micro-op s occupies `ret_ptags[s*PTAG_W +: PTAG_W]`, and `alloc_ptags` uses the same packing.
- R7: An exception stays inside its instruction until that instruction is the oldest and fully written back. The block then raises `flush_valid` for one cycle, with `flush_pc` equal to the parent instruction address. Already completed sibling micro-ops do not change this.
- R8: If several micro-ops of one instruction report exceptions, `flush_cause` is the code from the lowest micro-op position, whatever order the exceptions arrived in.
- R9: In the cycle a fault is taken, `alloc_ready` is 0. At the following edge the window becomes empty, and the next allocation gets the faulting instruction's slot index.
- R10: The faulting instruction and all younger instructions never retire, and `ret_valid` and `flush_valid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | New instruction offered |
| alloc_pc | input | ADDR_W | Instruction address |
| alloc_nuop_m1 | input | SLOT_W | Micro-op count minus one |
| alloc_ptags | input | MAX_UOPS*PTAG_W | Destination tag for each micro-op position |
| alloc_ready | output | 1 | Allocation is accepted this cycle |
| alloc_idx | output | IDX_W | Slot index given to the offered instruction |
| wb_valid | input | 1 | Micro-op completion event |
| wb_idx | input | IDX_W | Slot index carried by the micro-op |
| wb_slot | input | SLOT_W | Micro-op position within its instruction |
| wb_exc | input | 1 | The micro-op raised an exception |
| wb_code | input | EXC_W | Exception code |
| ret_valid | output | 1 | One instruction retired |
| ret_pc | output | ADDR_W | Address of the retired instruction |
| ret_nuop_m1 | output | SLOT_W | Micro-op count minus one of the retired instruction |
| ret_ptags | output | MAX_UOPS*PTAG_W | Destination tags now architecturally committed |
| flush_valid | output | 1 | Fault taken; flush younger work and redirect |
| flush_pc | output | ADDR_W | Address of the faulting instruction |
| flush_cause | output | EXC_W | Exception code being reported |

## Verification
Cracked instructions of one, two and four micro-ops are completed in reverse and interleaved order, which shows that retirement waits on the whole mask and not on the last arrival. Writebacks to empty slots, to positions beyond an instruction's count and to positions already written back show that ignored events can neither complete an entry nor plant an exception. A full window with an extra offer checks the stall. A two-exception instruction sitting behind a completed older one tells apart lowest-position selection from arrival order, and checks that the older one retires first and that allocation restarts at the faulting slot. A long random phase mixes allocations, completions and rare exceptions, so flushes land on cycles that also carry offers and writebacks.

// File: rtl/mrb_pkg.sv
package mrb_pkg;

  typedef enum logic [1:0] {
    HD_IDLE   = 2'd0,
    HD_WAIT   = 2'd1,
    HD_COMMIT = 2'd2,
    HD_FAULT  = 2'd3
  } head_state_e;

  function automatic int unsigned ring_next(int unsigned p, int unsigned depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/mrb_payload_ram.sv
module mrb_payload_ram #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/mrb_status.sv
module mrb_status #(
  parameter int DEPTH    = 16,
  parameter int MAX_UOPS = 4,
  parameter int EXC_W    = 4,
  localparam int IDX_W   = $clog2(DEPTH),
  localparam int SLOT_W  = (MAX_UOPS > 1) ? $clog2(MAX_UOPS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              retire,
  input  logic [IDX_W-1:0]  head,
  input  logic              alloc_we,
  input  logic [IDX_W-1:0]  alloc_at,
  input  logic [SLOT_W-1:0] alloc_nm1,
  input  logic              wb_valid,
  input  logic [IDX_W-1:0]  wb_idx,
  input  logic [SLOT_W-1:0] wb_slot,
  input  logic              wb_exc,
  input  logic [EXC_W-1:0]  wb_code,
  output logic              head_valid,
  output logic              head_done,
  output logic              head_exc,
  output logic [EXC_W-1:0]  head_code
);

  logic [MAX_UOPS-1:0] prefill;
  logic [DEPTH-1:0]    valid_vec;
  logic [MAX_UOPS-1:0] done_arr [DEPTH];
  logic                exc_arr  [DEPTH];
  logic [EXC_W-1:0]    code_arr [DEPTH];

  // Positions past the instruction's count start out as already done.
  always_comb begin
    for (int s = 0; s < MAX_UOPS; s++) begin
      prefill[s] = (s > int'(alloc_nm1));
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic                v_q;
    logic [MAX_UOPS-1:0] d_q;
    logic                x_q;
    logic [SLOT_W-1:0]   xs_q;
    logic [EXC_W-1:0]    c_q;
    logic                hit;
    logic                mine_alloc;
    logic                mine_retire;

    assign hit         = wb_valid && (wb_idx == IDX_W'(e)) && v_q && !d_q[wb_slot];
    assign mine_alloc  = alloc_we && (alloc_at == IDX_W'(e));
    assign mine_retire = retire && (head == IDX_W'(e));

    always_ff @(posedge clk) begin
      if (rst || flush) begin
        v_q  <= 1'b0;
        d_q  <= '0;
        x_q  <= 1'b0;
        xs_q <= '0;
        c_q  <= '0;
      end else if (mine_retire) begin
        v_q <= 1'b0;
      end else if (mine_alloc) begin
        v_q  <= 1'b1;
        d_q  <= prefill;
        x_q  <= 1'b0;
        xs_q <= '0;
        c_q  <= '0;
      end else if (hit) begin
        d_q[wb_slot] <= 1'b1;
        if (wb_exc && (!x_q || wb_slot < xs_q)) begin
          x_q  <= 1'b1;
          xs_q <= wb_slot;
          c_q  <= wb_code;
        end
      end
    end

    assign valid_vec[e] = v_q;
    assign done_arr[e]  = d_q;
    assign exc_arr[e]   = x_q;
    assign code_arr[e]  = c_q;
  end

  assign head_valid = valid_vec[head];
  assign head_done  = &done_arr[head];
  assign head_exc   = exc_arr[head];
  assign head_code  = code_arr[head];

endmodule

// File: rtl/mrb_ptrs.sv
module mrb_ptrs #(
  parameter int DEPTH  = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic             retire,
  input  logic             flush,
  output logic [IDX_W-1:0] head,
  output logic [IDX_W-1:0] tail,
  output logic [CNT_W-1:0] count,
  output logic             full
);
  import mrb_pkg::*;

  logic [IDX_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (flush) begin
      tail_q <= head_q;
      cnt_q  <= '0;
    end else begin
      if (retire) head_q <= IDX_W'(ring_next(int'(head_q), DEPTH));
      if (accept) tail_q <= IDX_W'(ring_next(int'(tail_q), DEPTH));
      case ({accept, retire})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head  = head_q;
  assign tail  = tail_q;
  assign count = cnt_q;
  assign full  = (cnt_q == CNT_W'(DEPTH));

endmodule

// File: rtl/mop_retire_buffer.sv
module mop_retire_buffer #(
  parameter int DEPTH    = 16,
  parameter int ADDR_W   = 32,
  parameter int PTAG_W   = 7,
  parameter int MAX_UOPS = 4,
  parameter int EXC_W    = 4,
  localparam int IDX_W   = $clog2(DEPTH),
  localparam int SLOT_W  = (MAX_UOPS > 1) ? $clog2(MAX_UOPS) : 1,
  localparam int TAGS_W  = MAX_UOPS * PTAG_W,
  localparam int CNT_W   = $clog2(DEPTH + 1),
  localparam int PAY_W   = ADDR_W + SLOT_W + TAGS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_valid,
  input  logic [ADDR_W-1:0] alloc_pc,
  input  logic [SLOT_W-1:0] alloc_nuop_m1,
  input  logic [TAGS_W-1:0] alloc_ptags,
  output logic              alloc_ready,
  output logic [IDX_W-1:0]  alloc_idx,
  input  logic              wb_valid,
  input  logic [IDX_W-1:0]  wb_idx,
  input  logic [SLOT_W-1:0] wb_slot,
  input  logic              wb_exc,
  input  logic [EXC_W-1:0]  wb_code,
  output logic              ret_valid,
  output logic [ADDR_W-1:0] ret_pc,
  output logic [SLOT_W-1:0] ret_nuop_m1,
  output logic [TAGS_W-1:0] ret_ptags,
  output logic              flush_valid,
  output logic [ADDR_W-1:0] flush_pc,
  output logic [EXC_W-1:0]  flush_cause
);
  import mrb_pkg::*;

  logic [IDX_W-1:0] head, tail;
  logic [CNT_W-1:0] cnt;
  logic             full;
  logic             head_valid, head_done, head_exc;
  logic [EXC_W-1:0] head_code;
  head_state_e      hstate;
  logic             commit, fault, accept;
  logic [PAY_W-1:0] pay_w, pay_r;

  always_comb begin
    if (!head_valid)    hstate = HD_IDLE;
    else if (!head_done) hstate = HD_WAIT;
    else if (head_exc)   hstate = HD_FAULT;
    else                 hstate = HD_COMMIT;
  end

  assign commit      = (hstate == HD_COMMIT);
  assign fault       = (hstate == HD_FAULT);
  assign alloc_ready = !full && !fault;
  assign accept      = alloc_valid && alloc_ready;
  assign alloc_idx   = tail;

  mrb_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk    (clk),
    .rst    (rst),
    .accept (accept),
    .retire (commit),
    .flush  (fault),
    .head   (head),
    .tail   (tail),
    .count  (cnt),
    .full   (full)
  );

  mrb_status #(.DEPTH(DEPTH), .MAX_UOPS(MAX_UOPS), .EXC_W(EXC_W)) u_status (
    .clk        (clk),
    .rst        (rst),
    .flush      (fault),
    .retire     (commit),
    .head       (head),
    .alloc_we   (accept),
    .alloc_at   (tail),
    .alloc_nm1  (alloc_nuop_m1),
    .wb_valid   (wb_valid),
    .wb_idx     (wb_idx),
    .wb_slot    (wb_slot),
    .wb_exc     (wb_exc),
    .wb_code    (wb_code),
    .head_valid (head_valid),
    .head_done  (head_done),
    .head_exc   (head_exc),
    .head_code  (head_code)
  );

  assign pay_w = {alloc_nuop_m1, alloc_ptags, alloc_pc};

  // Read of the head slot is registered, lining up with the status registers below.
  mrb_payload_ram #(.DEPTH(DEPTH), .WIDTH(PAY_W)) u_pay (
    .clk   (clk),
    .we    (accept),
    .waddr (tail),
    .wdata (pay_w),
    .raddr (head),
    .rdata (pay_r)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ret_valid   <= 1'b0;
      flush_valid <= 1'b0;
      flush_cause <= '0;
    end else begin
      ret_valid   <= commit;
      flush_valid <= fault;
      flush_cause <= fault ? head_code : flush_cause;
    end
  end

  assign ret_pc      = pay_r[ADDR_W-1:0];
  assign ret_ptags   = pay_r[ADDR_W +: TAGS_W];
  assign ret_nuop_m1 = pay_r[ADDR_W+TAGS_W +: SLOT_W];
  assign flush_pc    = pay_r[ADDR_W-1:0];

endmodule

// File: rtl/mrb_checker.sv
module mrb_checker #(
  parameter int DEPTH  = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             alloc_valid,
  input logic             alloc_ready,
  input logic             ret_valid,
  input logic             flush_valid,
  input logic [IDX_W-1:0] head,
  input logic [IDX_W-1:0] tail,
  input logic [CNT_W-1:0] cnt
);

  logic took;
  assign took = alloc_valid && alloc_ready && !rst;

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    int'(cnt) <= DEPTH);

  // R2: occupancy follows accepted allocations and retirements
  p_cnt_track_r2: assert property (@(posedge clk) disable iff (rst)
    !flush_valid |-> int'(cnt) == int'($past(cnt)) + int'($past(took)) - int'(ret_valid));

  p_head_step_r4: assert property (@(posedge clk) disable iff (rst)
    ret_valid |-> int'(head) == (int'($past(head)) + 1) % DEPTH);

  p_ret_nonempty_r4: assert property (@(posedge clk) disable iff (rst)
    ret_valid |-> $past(cnt) != '0);

  p_flush_head_r7: assert property (@(posedge clk) disable iff (rst)
    flush_valid |-> head == $past(head));

  p_flush_empty_r9: assert property (@(posedge clk) disable iff (rst)
    flush_valid |-> (cnt == '0) && (tail == head));

  p_flush_refuse_r9: assert property (@(posedge clk) disable iff (rst)
    flush_valid |-> $past(!alloc_ready));

  p_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(flush_valid && ret_valid));

endmodule

bind mop_retire_buffer mrb_checker #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .alloc_valid (alloc_valid),
  .alloc_ready (alloc_ready),
  .ret_valid   (ret_valid),
  .flush_valid (flush_valid),
  .head        (head),
  .tail        (tail),
  .cnt         (cnt)
);

// File: tb/mop_retire_buffer_tb.sv
module mop_retire_buffer_tb;
  localparam int DEPTH = 16, AW = 32, PW = 7, NU = 4, EW = 4;
  localparam int IW = 4, SW = 2, TW = NU * PW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic          alloc_valid = 0;
  logic [AW-1:0] alloc_pc = '0;
  logic [SW-1:0] alloc_nuop_m1 = '0;
  logic [TW-1:0] alloc_ptags = '0;
  logic          wb_valid = 0;
  logic [IW-1:0] wb_idx = '0;
  logic [SW-1:0] wb_slot = '0;
  logic          wb_exc = 0;
  logic [EW-1:0] wb_code = '0;
  logic          alloc_ready, ret_valid, flush_valid;
  logic [IW-1:0] alloc_idx;
  logic [AW-1:0] ret_pc, flush_pc;
  logic [SW-1:0] ret_nuop_m1;
  logic [TW-1:0] ret_ptags;
  logic [EW-1:0] flush_cause;

  mop_retire_buffer u_dut (
    .clk(clk), .rst(rst),
    .alloc_valid(alloc_valid), .alloc_pc(alloc_pc), .alloc_nuop_m1(alloc_nuop_m1),
    .alloc_ptags(alloc_ptags), .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
    .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_slot(wb_slot), .wb_exc(wb_exc), .wb_code(wb_code),
    .ret_valid(ret_valid), .ret_pc(ret_pc), .ret_nuop_m1(ret_nuop_m1), .ret_ptags(ret_ptags),
    .flush_valid(flush_valid), .flush_pc(flush_pc), .flush_cause(flush_cause)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // Behavioural model: window of m_cnt instructions starting at m_head
  logic [AW-1:0] m_pc   [DEPTH];
  logic [SW-1:0] m_nm1  [DEPTH];
  logic [TW-1:0] m_tag  [DEPTH];
  logic [NU-1:0] m_done [DEPTH];
  bit            m_ex   [DEPTH];
  int            m_exs  [DEPTH];
  logic [EW-1:0] m_code [DEPTH];
  int m_head = 0, m_cnt = 0;
  int ret_seen = 0, flush_seen = 0;
  logic [AW-1:0] last_flush_pc = '0;
  logic [EW-1:0] last_cause = '0;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit in_window(int idx);
    return ((idx - m_head + DEPTH) % DEPTH) < m_cnt;
  endfunction

  // Called just after a falling edge with inputs already driven.
  task automatic step();
    int h, tl, wi, ws;
    bit cpl, fault, commit, e_ready, acc;
    logic [AW-1:0] e_pc;
    logic [TW-1:0] e_tag;
    logic [SW-1:0] e_nm1;
    logic [EW-1:0] e_code;
    #1;
    h = m_head;
    cpl = (m_cnt > 0) && (&m_done[h]);
    fault = cpl && m_ex[h];
    commit = cpl && !m_ex[h];
    e_ready = (m_cnt < DEPTH) && !fault;
    tl = (m_head + m_cnt) % DEPTH;
    chk("R3", "alloc_ready", alloc_ready, e_ready);
    chk("R2", "alloc_idx", alloc_idx, tl);
    e_pc = m_pc[h]; e_tag = m_tag[h]; e_nm1 = m_nm1[h]; e_code = m_code[h];
    acc = alloc_valid && e_ready;
    if (fault) begin
      m_cnt = 0;
    end else begin
      wi = int'(wb_idx); ws = int'(wb_slot);
      if (wb_valid && in_window(wi) && !m_done[wi][ws]) begin
        m_done[wi][ws] = 1'b1;
        if (wb_exc && (!m_ex[wi] || ws < m_exs[wi])) begin
          m_ex[wi] = 1; m_exs[wi] = ws; m_code[wi] = wb_code;
        end
      end
      if (commit) begin
        m_head = (m_head + 1) % DEPTH;
        m_cnt--;
      end
      if (acc) begin
        m_pc[tl] = alloc_pc; m_nm1[tl] = alloc_nuop_m1; m_tag[tl] = alloc_ptags;
        for (int s = 0; s < NU; s++) m_done[tl][s] = (s > int'(alloc_nuop_m1));
        m_ex[tl] = 0; m_exs[tl] = 0; m_code[tl] = '0;
        m_cnt++;
      end
    end
    @(posedge clk); #1;
    chk("R4", "ret_valid", ret_valid, commit);
    if (commit) begin
      chk("R6", "ret_pc", ret_pc, e_pc);
      chk("R6", "ret_ptags", ret_ptags, e_tag);
      chk("R6", "ret_nuop_m1", ret_nuop_m1, e_nm1);
      ret_seen++;
    end
    chk("R7", "flush_valid", flush_valid, fault);
    chk("R10", "ret/flush overlap", ret_valid && flush_valid, 0);
    if (fault) begin
      chk("R7", "flush_pc", flush_pc, e_pc);
      chk("R8", "flush_cause", flush_cause, e_code);
      last_flush_pc = flush_pc; last_cause = flush_cause;
      flush_seen++;
    end
    alloc_valid = 0; wb_valid = 0; wb_exc = 0;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic do_alloc(logic [AW-1:0] pc, int nm1, output int idx);
    idx = (m_head + m_cnt) % DEPTH;
    alloc_valid = 1; alloc_pc = pc; alloc_nuop_m1 = SW'(nm1);
    alloc_ptags = {$urandom, $urandom};
    step();
  endtask

  task automatic do_wb(int idx, int slot, bit exc, int code);
    wb_valid = 1; wb_idx = IW'(idx); wb_slot = SW'(slot); wb_exc = exc; wb_code = EW'(code);
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int i0, i1, i2, ic, base, r0, j0, j1, j2, j3, tmp;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #1;
    chk("R1", "reset alloc_ready", alloc_ready, 1);
    chk("R1", "reset alloc_idx", alloc_idx, 0);
    chk("R1", "reset ret_valid", ret_valid, 0);
    chk("R1", "reset flush_valid", flush_valid, 0);
    @(negedge clk);

    // Cracked instructions completed out of order (R4, R5, R6)
    do_alloc(32'h1000, 0, i0);
    do_alloc(32'h1004, 3, i1);
    do_alloc(32'h100c, 1, i2);
    do_wb(i2, 1, 0, 0);
    do_wb(i2, 0, 0, 0);
    do_wb(i1, 3, 0, 0);
    do_wb(i1, 1, 0, 0);
    do_wb(i0, 0, 0, 0);
    idle(2);
    chk("R4", "only oldest retired while middle waits", ret_seen, 1);
    do_wb(i1, 0, 0, 0);
    do_wb(i1, 2, 0, 0);
    idle(4);
    chk("R4", "all three retired", ret_seen, 3);

    // Ignored writebacks (R5)
    base = ret_seen;
    do_wb((m_head + m_cnt) % DEPTH, 0, 1, 3);
    do_alloc(32'h2000, 0, ic);
    do_wb(ic, 2, 1, 6);
    do_wb(ic, 3, 0, 0);
    idle(3);
    chk("R5", "no retire after ignored writebacks", ret_seen - base, 0);
    do_wb(ic, 0, 0, 0);
    do_wb(ic, 0, 1, 7);
    idle(3);
    chk("R5", "retired once, no flush from stray exceptions", ret_seen - base, 1);
    chk("R5", "no flush from ignored exceptions", flush_seen, 0);

    // Fill to capacity (R3)
    base = m_cnt;
    r0 = (m_head + m_cnt) % DEPTH;
    for (int k = 0; k < DEPTH; k++) do_alloc(32'h3000 + 4 * k, 0, tmp);
    #1;
    chk("R3", "not ready when full", alloc_ready, 0);
    tmp = int'(alloc_idx);
    do_alloc(32'h3fff0, 0, i0);
    #1;
    chk("R3", "index unchanged by refused offer", alloc_idx, tmp);
    @(negedge clk);
    for (int k = DEPTH - 1; k >= 0; k--) do_wb((r0 + k) % DEPTH, 0, 0, 0);
    base = ret_seen;
    idle(DEPTH + 3);
    chk("R4", "full window drains one per cycle", ret_seen - base, DEPTH);

    // Fault with two exceptions behind an older instruction (R7, R8, R9, R10)
    base = ret_seen;
    do_alloc(32'h4000, 0, j0);
    do_alloc(32'h4004, 2, j1);
    do_alloc(32'h4010, 0, j2);
    do_alloc(32'h4014, 1, j3);
    do_wb(j2, 0, 0, 0);
    do_wb(j1, 0, 0, 0);
    do_wb(j1, 2, 1, 5);
    do_wb(j1, 1, 1, 9);
    do_wb(j3, 0, 0, 0);
    do_wb(j3, 1, 0, 0);
    do_wb(j0, 0, 0, 0);
    idle(4);
    chk("R10", "only the older instruction retired", ret_seen - base, 1);
    chk("R7", "one flush", flush_seen, 1);
    chk("R7", "flush address is parent", last_flush_pc, 32'h4004);
    chk("R8", "lowest position cause", last_cause, 9);
    #1;
    chk("R9", "next index is faulting slot", alloc_idx, j1);
    @(negedge clk);

    // Random mix
    for (int c = 0; c < 3000; c++) begin
      alloc_valid = ($urandom % 2) == 0;
      alloc_pc = {$urandom} & 32'hfffffffc;
      alloc_nuop_m1 = SW'($urandom);
      alloc_ptags = {$urandom, $urandom};
      if (m_cnt > 0 && ($urandom % 4) != 0) begin
        wb_idx = IW'((m_head + ($urandom % m_cnt)) % DEPTH);
      end else begin
        wb_idx = IW'($urandom);
      end
      wb_valid = ($urandom % 5) != 0;
      wb_slot = SW'($urandom);
      wb_exc = ($urandom % 25) == 0;
      wb_code = EW'($urandom);
      step();
    end
    idle(4);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule